// File: doc/BRIEF.md
# Synchronous Hit Timestamp Trigger

This block turns an asynchronous pulse from a front-end discriminator into a clock-aligned event. The raw comparator output is synchronized into the system clock domain (nominally 40 MHz, 25 ns per tick) and its rising edge is detected. On the first active clock edge that sees that edge, the block does two things together. It copies a free-running coarse time counter into a timestamp register, and it raises a one-cycle launch strobe toward a waveform digitizer. Because both happen on the same edge, the launch is tied rigidly to the recorded time. The hit itself can sit anywhere inside one clock period before that edge.

After a trigger the block does not re-arm until the comparator output has gone low again, so one long pulse produces one trigger. A hit that arrives while the digitizer reports busy, or while the block has not yet re-armed, produces no launch. It only increments a saturating dead-time counter. A synchronous reset returns every register to its cleared state.

Top module: `hit_stamp_trigger`

## Requirements
- R1: While `rst` is high at a rising clock edge, the coarse counter, `ts_out`, `ts_valid`, `launch`, the trigger state and `dead_count` are all cleared to zero or idle, and `busy` reads 0 unless `dig_busy` is high.
- R2: The coarse counter starts at 0 on the first edge after reset, increments by one on every clock edge and wraps from all ones to 0 without any indication.
- R3: A rising edge on `hit_raw` is taken on the (SYNC_STAGES+1)-th rising clock edge after it, which is the 3rd edge with the default of 2. This applies when the block is idle and `dig_busy` is low. On that edge `launch` rises and `ts_out` takes the counter value held just before that edge.
- R4: `launch` is high for exactly one clock cycle per accepted hit.
- R5: `ts_valid` is high for exactly the one cycle after `launch`. `ts_out` keeps its value until the next accepted hit.
- R6: A pulse held high for any number of cycles gives one launch only. The block re-arms on the (SYNC_STAGES+1)-th edge after `hit_raw` falls.
- R7: A rising hit edge seen while `dig_busy` is high, or while the block is not re-armed, gives no launch and leaves `ts_out` unchanged. It adds 1 to `dead_count`.
- R8: `dead_count` saturates at all ones (2^DEAD_W-1) and never wraps.
- R9: `busy` is high whenever `dig_busy` is high or the block is between an accepted hit and its re-arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System time-base clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_raw | input | 1 | Asynchronous comparator output |
| dig_busy | input | 1 | Digitizer is occupied, active high |
| launch | output | 1 | One-cycle start strobe to the digitizer |
| ts_out | output | TS_W | Coarse timestamp of the last accepted hit |
| ts_valid | output | 1 | One-cycle flag: `ts_out` holds a new value |
| busy | output | 1 | Block cannot accept a hit |
| dead_count | output | DEAD_W | Saturating count of rejected hits |

## Verification
A hit driven between edges reaches `launch` after SYNC_STAGES+1 rising edges: the synchronizer stages, then the registered trigger state. `ts_valid` follows one edge later, and the re-arm that clears `busy` comes the same number of edges after the input falls. The bench drives every input at the falling edge and counts rising edges explicitly. It samples at the falling edge that follows the edge where a result is due, and also one sample earlier to confirm the result has not appeared early. Expected timestamps come from a bench cycle count that is started by the same reset and taken modulo the narrowed counter width used in the bench.

// File: rtl/hst_pkg.sv
package hst_pkg;
   typedef enum logic {
      ST_ARMED = 1'b0,
      ST_HELD  = 1'b1
   } hst_state_e;
endpackage

// File: rtl/hst_sync.sv
module hst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              level_d;

   generate
      if (STAGES < 2) begin : g_bad
         initial $error("hst_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[0], din};
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) level_d <= 1'b0;
      else     level_d <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~level_d;
endmodule

// File: rtl/hst_coarse_ctr.sv
module hst_coarse_ctr #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 2) begin : g_bad
         initial $error("hst_coarse_ctr: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) count <= '0;
      else     count <= count + ONE;
   end
endmodule

// File: rtl/hst_sat_ctr.sv
module hst_sat_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 1) begin : g_bad
         initial $error("hst_sat_ctr: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                     count <= '0;
      else if (inc && count != TOP) count <= count + ONE;
   end
endmodule

// File: rtl/hst_trig_fsm.sv
module hst_trig_fsm
   import hst_pkg::*;
#(
   parameter int TS_W = 48
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            rise,
   input  logic            level,
   input  logic            dig_busy,
   input  logic [TS_W-1:0] coarse,
   output logic            launch,
   output logic [TS_W-1:0] ts,
   output logic            ts_valid,
   output logic            armed,
   output logic            reject
);
   hst_state_e state, state_nx;
   logic       accept;

   assign armed  = (state == ST_ARMED);
   assign accept = rise & armed & ~dig_busy;
   assign reject = rise & ~accept;

   always_comb begin
      state_nx = state;
      case (state)
         ST_ARMED: if (accept) state_nx = ST_HELD;
         ST_HELD:  if (!level) state_nx = ST_ARMED;
         default:  state_nx = ST_ARMED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_ARMED;
         launch   <= 1'b0;
         ts_valid <= 1'b0;
         ts       <= '0;
      end else begin
         state    <= state_nx;
         launch   <= accept;
         ts_valid <= launch;
         if (accept) ts <= coarse;
      end
   end
endmodule

// File: rtl/hit_stamp_trigger.sv
module hit_stamp_trigger #(
   parameter int TS_W        = 48,
   parameter int DEAD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hit_raw,
   input  logic              dig_busy,
   output logic              launch,
   output logic [TS_W-1:0]   ts_out,
   output logic              ts_valid,
   output logic              busy,
   output logic [DEAD_W-1:0] dead_count
);
   logic            hit_level;
   logic            hit_rise;
   logic [TS_W-1:0] coarse;
   logic            armed;
   logic            reject;

   generate
      if (TS_W > 64) begin : g_bad_ts
         initial $error("hit_stamp_trigger: TS_W above 64 not supported");
      end
   endgenerate

   hst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .din   (hit_raw),
      .level (hit_level),
      .rise  (hit_rise)
   );

   hst_coarse_ctr #(.W(TS_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .count (coarse)
   );

   hst_trig_fsm #(.TS_W(TS_W)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .rise     (hit_rise),
      .level    (hit_level),
      .dig_busy (dig_busy),
      .coarse   (coarse),
      .launch   (launch),
      .ts       (ts_out),
      .ts_valid (ts_valid),
      .armed    (armed),
      .reject   (reject)
   );

   hst_sat_ctr #(.W(DEAD_W)) u_dead (
      .clk   (clk),
      .rst   (rst),
      .inc   (reject),
      .count (dead_count)
   );

   assign busy = dig_busy | ~armed;
endmodule

// File: rtl/hst_checker.sv
module hst_checker #(
   parameter int TS_W   = 48,
   parameter int DEAD_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              dig_busy,
   input logic              launch,
   input logic [TS_W-1:0]   ts_out,
   input logic              ts_valid,
   input logic              busy,
   input logic [DEAD_W-1:0] dead_count,
   input logic [TS_W-1:0]   coarse
);
   localparam logic [TS_W-1:0] ONE = {{(TS_W-1){1'b0}}, 1'b1};

   // R2
   a_r2_counter_steps: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> coarse == $past(coarse) + ONE);
   // R4
   a_r4_launch_single: assert property (@(posedge clk) disable iff (rst)
      launch |=> !launch);
   // R5
   a_r5_valid_after_launch: assert property (@(posedge clk) disable iff (rst)
      launch |=> ts_valid);
   a_r5_ts_holds: assert property (@(posedge clk) disable iff (rst)
      !launch |-> $stable(ts_out));
   // R7
   a_r7_no_launch_when_busy: assert property (@(posedge clk) disable iff (rst)
      launch |-> !$past(dig_busy));
   // R8
   a_r8_dead_monotonic: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> dead_count >= $past(dead_count));
   // R9
   a_r9_busy_after_launch: assert property (@(posedge clk) disable iff (rst)
      launch |-> busy);
endmodule

bind hit_stamp_trigger hst_checker #(.TS_W(TS_W), .DEAD_W(DEAD_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .dig_busy   (dig_busy),
   .launch     (launch),
   .ts_out     (ts_out),
   .ts_valid   (ts_valid),
   .busy       (busy),
   .dead_count (dead_count),
   .coarse     (coarse)
);

// File: tb/sim_hit_stamp_trigger.sv
`timescale 1ns/1ps
module sim_hit_stamp_trigger;
   localparam int TS_W   = 8;
   localparam int DEAD_W = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              hit_raw = 1'b0;
   logic              dig_busy = 1'b0;
   logic              launch;
   logic [TS_W-1:0]   ts_out;
   logic              ts_valid;
   logic              busy;
   logic [DEAD_W-1:0] dead_count;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int nlaunch = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   hit_stamp_trigger #(.TS_W(TS_W), .DEAD_W(DEAD_W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst(rst), .hit_raw(hit_raw), .dig_busy(dig_busy),
      .launch(launch), .ts_out(ts_out), .ts_valid(ts_valid),
      .busy(busy), .dead_count(dead_count)
   );

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
      if (!rst && launch) nlaunch <= nlaunch + 1;
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      wait_neg(3);
      check("R1 launch", launch, 0);
      check("R1 ts_out", ts_out, 0);
      check("R1 ts_valid", ts_valid, 0);
      check("R1 busy", busy, 0);
      check("R1 dead_count", dead_count, 0);
      rst = 1'b0;
      wait_neg(1);
   endtask

   // R3 R4 R5: single accepted hit
   task automatic t_single(input int width);
      logic [TS_W-1:0] exp_ts;
      hit_raw = 1'b1;
      wait_neg(2);
      check("R3 launch not early", launch, 0);
      if (width <= 2) hit_raw = 1'b0;
      wait_neg(1);
      exp_ts = TS_W'(cyc - 1);
      check("R3 launch on 3rd edge", launch, 1);
      check("R3 timestamp", ts_out, exp_ts);
      check("R9 busy while held", busy, 1);
      wait_neg(1);
      check("R4 launch one cycle", launch, 0);
      check("R5 ts_valid after launch", ts_valid, 1);
      hit_raw = 1'b0;
      wait_neg(1);
      check("R5 ts_valid one cycle", ts_valid, 0);
      check("R5 ts_out holds", ts_out, exp_ts);
      wait_neg(4);
      check("R6 re-armed", busy, 0);
   endtask

   // R6 R9: long pulse
   task automatic t_long;
      int base;
      base = nlaunch;
      hit_raw = 1'b1;
      wait_neg(20);
      check("R6 one launch for long pulse", nlaunch - base, 1);
      check("R9 busy during long pulse", busy, 1);
      hit_raw = 1'b0;
      wait_neg(2);
      check("R6 still held before re-arm", busy, 1);
      wait_neg(1);
      check("R6 re-arm on 3rd edge after fall", busy, 0);
   endtask

   // R7 R9: hit during digitizer busy
   task automatic t_busy_hit;
      logic [TS_W-1:0] old_ts;
      logic [DEAD_W-1:0] old_dead;
      int base;
      old_ts = ts_out;
      old_dead = dead_count;
      base = nlaunch;
      dig_busy = 1'b1;
      wait_neg(1);
      check("R9 busy follows dig_busy", busy, 1);
      hit_raw = 1'b1;
      wait_neg(2);
      hit_raw = 1'b0;
      wait_neg(5);
      check("R7 no launch while busy", nlaunch - base, 0);
      check("R7 ts_out unchanged", ts_out, old_ts);
      check("R7 dead_count incremented", dead_count, old_dead + 1);
      dig_busy = 1'b0;
      wait_neg(1);
      check("R9 busy clears", busy, 0);
   endtask

   // R8: saturation
   task automatic t_saturate;
      dig_busy = 1'b1;
      for (int i = 0; i < 20; i++) begin
         hit_raw = 1'b1;
         wait_neg(2);
         hit_raw = 1'b0;
         wait_neg(4);
      end
      check("R8 dead_count saturates", dead_count, 15);
      dig_busy = 1'b0;
      wait_neg(2);
   endtask

   // R2: wrap of counter visible in timestamps
   task automatic t_wrap;
      while (cyc < 300) wait_neg(1);
      check("R2 counter passed wrap", cyc > 256, 1);
      t_single(2);
   endtask

   initial begin
      wait_neg(1);
      t_reset;
      t_single(2);
      t_single(5);
      t_long;
      t_busy_hit;
      t_saturate;
      t_single(3);
      t_wrap;
      t_reset;
      check("R1 dead_count cleared again", dead_count, 0);
      check("R2 counter restarts", ts_out, 0);
      t_single(2);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule